// File: doc/BRIEF.md
# Phase-Interleaved Fine/Coarse Programmable Delay

This block delays a digitised detector pulse with a time resolution finer than its own clock period. The fast timing grid is split into `LANES` equally spaced phases of a slow clock. Each phase takes its own sample of the input, and those samples reach the block together as one `LANES`-bit vector per slow cycle. Every lane then passes through the same coarse delay line. That line is built from binary-weighted segments of 1, 2, 4 and more register stages, and each segment is either used or bypassed according to one bit of the coarse code.

The delay word has two fields. The low `log2(LANES)` bits, the fine field, choose which lane is sent to the single pulse output. Choosing a lane this way recovers the sub-cycle step. The upper `COARSE_W` bits, the coarse code, set how many slow cycles all lanes are held together. Any pattern of pulses passes with no dead time, including a pulse on every lane in consecutive cycles.

A typical use keeps the coarse code steady for long stretches and retunes the fine field as tracking geometry drifts.

Top module: `phase_delay_unit`

## Requirements
- R1: A low `rst_n` at a rising edge clears `lanes_out` and `pulse_out` to zero after that edge.
- R2: With the coarse code C = `delay_word[8:3]` held steady, the vector sampled on `phase_in` at a rising edge appears on `lanes_out` just after the rising edge C+1 edges later.
- R3: Coarse code 0 gives the minimum latency of one edge: `lanes_out` after edge n equals `phase_in` sampled at edge n-1.
- R4: Every coarse code from 0 to 63 is honoured, so the longest latency is 64 slow cycles.
- R5: `pulse_out` after edge n equals bit F of `lanes_out` after edge n, where F = `delay_word[2:0]` as sampled at edge n, and bit i of `phase_in` is lane i.
- R6: A change confined to the fine field takes effect on the output of the edge that samples it, with no flush and no lost or duplicated pulses.
- R7: All lanes get the same coarse delay independently: any bit pattern, including all ones on consecutive cycles, is reproduced without dead time.
- R8: After the coarse code changes, the outputs obey R2 again once the new code has been held for 66 edges.
- R9: After 66 consecutive edges with `phase_in` all zero, `lanes_out` and `pulse_out` are zero, whatever the coarse code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, one sample vector per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 8 | Phase samples of the input pulse, bit i = phase i |
| delay_word | input | 9 | [8:3] coarse code in slow cycles, [2:0] fine lane index |
| lanes_out | output | 8 | All lanes after the coarse delay |
| pulse_out | output | 1 | Delayed pulse from the lane chosen by the fine field |

## Verification
Fine-field retuning and pulse arrival can fall on the same edge. The new lane index is sampled at the moment a delayed vector reaches the output register. The bench retunes the fine field every few cycles while random, sparse and all-ones vectors are in flight. On every cycle it compares the selected bit against a history-based model that pairs the vector from C+1 edges earlier with the fine value of the current edge. Coarse retuning is judged separately, after the settling window of R8.

// File: rtl/pdu_pkg.sv
// Package: shared defaults for the phase-interleaved delay unit.
// Assumes LANES is a power of two so the fine field indexes lanes exactly.
package pdu_pkg;
    localparam int unsigned PDU_LANES    = 8;
    localparam int unsigned PDU_COARSE_W = 6;
endpackage

// File: rtl/pdu_segment.sv
// Module: one binary-weighted segment of the coarse delay line.
// Holds DEPTH register stages of a LANES-wide vector. The stages shift on
// every clock; en picks either the last stage or the undelayed input.
// Assumes DEPTH >= 1.
module pdu_segment #(
    parameter int LANES = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    logic [LANES-1:0] stage_q [DEPTH];

    // Shift the vector through all stages each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Route through the stages or around them
    always_comb dout = en ? stage_q[DEPTH-1] : din;
endmodule

// File: rtl/pdu_coarse_chain.sv
// Module: coarse delay of all lanes, built from segments of 1, 2, 4 ... stages.
// Bit k of the coarse code enables the segment of 2**k stages, so the total
// delay in cycles equals the code. Combinational from din when the code is 0.
module pdu_coarse_chain #(
    parameter int LANES    = 8,
    parameter int COARSE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COARSE_W-1:0] code,
    input  logic [LANES-1:0]    din,
    output logic [LANES-1:0]    dout
);
    logic [LANES-1:0] link [COARSE_W+1];

    assign link[0] = din;

    for (genvar k = 0; k < COARSE_W; k++) begin : g_seg
        pdu_segment #(
            .LANES(LANES),
            .DEPTH(1 << k)
        ) u_seg (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (code[k]),
            .din  (link[k]),
            .dout (link[k+1])
        );
    end

    assign dout = link[COARSE_W];
endmodule

// File: rtl/pdu_lane_select.sv
// Module: registered lane picker that restores the fine step.
// Registers the lane chosen by the fine index, aligned with the lane register
// at the top level so the pulse and the lane vector leave on the same edge.
module pdu_lane_select #(
    parameter int LANES  = 8,
    parameter int FINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FINE_W-1:0] fine,
    input  logic [LANES-1:0]  lanes,
    output logic              pulse
);
    // Capture the chosen lane each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= lanes[fine];
    end
endmodule

// File: rtl/phase_delay_unit.sv
// Module: phase-interleaved fine/coarse programmable delay (top).
// Captures the phase vector, delays all lanes by the coarse code, and
// registers both the lane vector and the lane picked by the fine field.
// Latency from the capture edge is coarse code + 1 edges.
// Assumes the coarse code is held steady while pulses of interest pass.
module phase_delay_unit
    import pdu_pkg::*;
#(
    parameter int LANES    = PDU_LANES,
    parameter int COARSE_W = PDU_COARSE_W,
    localparam int FINE_W  = $clog2(LANES),
    localparam int DLY_W   = FINE_W + COARSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] phase_in,
    input  logic [DLY_W-1:0] delay_word,
    output logic [LANES-1:0] lanes_out,
    output logic             pulse_out
);
    localparam int QUIET_LIM = (1 << COARSE_W) + 2;
    localparam int QUIET_W   = $clog2(QUIET_LIM + 1);

    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse;
    logic [LANES-1:0]    cap_q, chain_out, lanes_q;

    assign fine   = delay_word[FINE_W-1:0];
    assign coarse = delay_word[DLY_W-1:FINE_W];

    // Capture stage standing in for the per-phase latches
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= phase_in;
    end

    pdu_coarse_chain #(
        .LANES   (LANES),
        .COARSE_W(COARSE_W)
    ) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .code (coarse),
        .din  (cap_q),
        .dout (chain_out)
    );

    // Output register for the delayed lane vector
    always_ff @(posedge clk) begin
        if (!rst_n) lanes_q <= '0;
        else        lanes_q <= chain_out;
    end

    pdu_lane_select #(
        .LANES (LANES),
        .FINE_W(FINE_W)
    ) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .fine (fine),
        .lanes(chain_out),
        .pulse(pulse_out)
    );

    assign lanes_out = lanes_q;

    // ---------------- checking support ----------------
    logic [1:0]         warm_q;
    logic [QUIET_W-1:0] quiet_q;

    // Count edges since reset, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // Count consecutive edges with an all-zero input, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || phase_in != '0)  quiet_q <= '0;
        else if (int'(quiet_q) < QUIET_LIM) quiet_q <= quiet_q + 1'b1;
    end

    // R5
    sel_matches_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out == lanes_out[$past(fine)]);

    // R3
    zero_coarse_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && $past(coarse) == '0) |-> lanes_out == $past(phase_in, 2));

    // R9
    quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(quiet_q) >= QUIET_LIM) |-> lanes_out == '0);

    // R9
    quiet_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(quiet_q) >= QUIET_LIM) |-> !pulse_out);
endmodule

// File: tb/tb_phase_delay_unit.sv
// Bench: behavioural history model compared with the outputs every cycle.
module tb_phase_delay_unit;
    localparam int HL = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] phase_in = '0;
    logic [8:0] delay_word = '0;
    logic [7:0] lanes_out;
    logic       pulse_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] in_h [HL];
    logic [2:0] fine_h [HL];

    phase_delay_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_in  (phase_in),
        .delay_word(delay_word),
        .lanes_out (lanes_out),
        .pulse_out (pulse_out)
    );

    always #10 clk = ~clk;

    // mode 0: no check, 1: compare with model, 2: expect all zero
    task automatic tick(input logic [7:0] v, input logic [8:0] d, input logic r,
                        input int mode, input string tag);
        logic [7:0] exp_l;
        logic       exp_p;
        int c;
        @(negedge clk);
        if (mode == 1) begin
            c = int'(delay_word[8:3]);
            exp_l = in_h[(cyc - 1 - c + HL) % HL];
            exp_p = exp_l[fine_h[cyc % HL]];
        end else begin
            exp_l = '0;
            exp_p = 1'b0;
        end
        if (mode != 0) begin
            n_cmp++;
            if (lanes_out !== exp_l || pulse_out !== exp_p) begin
                n_bad++;
                $display("FAIL %s cyc=%0d lanes=%h/%b expected %h/%b",
                         tag, cyc, lanes_out, pulse_out, exp_l, exp_p);
            end
        end
        phase_in = v;
        delay_word = d;
        rst_n = r;
        @(posedge clk);
        cyc++;
        in_h[cyc % HL] = v;
        fine_h[cyc % HL] = d[2:0];
    endtask

    function automatic logic [7:0] pattern(input int i);
        case ((i / 10) % 3)
            0:       return 8'($urandom);
            1:       return 8'(1 << ($urandom % 8));
            default: return 8'hFF;
        endcase
    endfunction

    initial begin
        int codes [8] = '{0, 1, 5, 42, 63, 31, 32, 2};
        logic [2:0] f;
        // R1: reset clears outputs
        for (int i = 0; i < 3; i++) tick(8'h00, 9'd0, 1'b0, 0, "R1");
        tick(8'hA5, 9'd0, 1'b1, 2, "R1 reset state");
        // R2 R3 R4 R7 R8 R5 R6: per coarse code, settle then compare
        foreach (codes[k]) begin
            f = 3'($urandom);
            for (int i = 0; i < 70; i++)
                tick(8'($urandom), {6'(codes[k]), f}, 1'b1, (k == 0 && i < 2) ? 0 : 0, "R8 settle");
            for (int i = 0; i < 150; i++) begin
                if (i % 5 == 0) f = 3'($urandom); // R6 fine retune in flight
                tick(pattern(i), {6'(codes[k]), f}, 1'b1, 1,
                     codes[k] == 0 ? "R3 R5 R6 R7" : "R2 R4 R5 R6 R7 R8");
            end
        end
        // R9: quiet input flushes outputs at the longest code
        for (int i = 0; i < 30; i++) tick(8'hFF, 9'h1FB, 1'b1, 0, "R9 fill");
        for (int i = 0; i < 67; i++) tick(8'h00, 9'h1FB, 1'b1, 0, "R9 drain");
        for (int i = 0; i < 10; i++) tick(8'h00, 9'h1FB, 1'b1, 2, "R9 quiet");
        // R1: reset in mid-run
        for (int i = 0; i < 20; i++) tick(8'hFF, 9'h01C, 1'b1, 0, "R1 load");
        tick(8'hFF, 9'h01C, 1'b0, 0, "R1 assert");
        tick(8'h00, 9'h01C, 1'b1, 2, "R1 mid-run reset");
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        n_bad++;
        $display("FAIL watchdog expired at cyc=%0d expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule